// File: doc/BRIEF.md
# Byte-Wide Host to 16-Bit ATA Task-File Bridge

This block connects an 8-bit PC I/O bus to a 16-bit ATA drive port. It claims a window of sixteen consecutive I/O ports, starting at a base address chosen by a parameter. Each byte access the host makes in that window becomes either an ATA task-file cycle or a local access to a one-byte holding register. ATA cycles use a chip select, a 3-bit register address, a fixed-length read or write strobe, and a 16-bit data word.

The ATA data register is 16 bits wide, and the host bus moves only bytes. The holding register bridges the two. A data-port read returns the low byte of the drive word and stores the high byte for a later read at the holding-register offset. A data-port write takes its high byte from the holding register, which the host loads beforehand.

The host pulses a one-cycle read or write request and then waits for a one-cycle acknowledge. Read data stays on the host output until the next claimed access loads it again.

Top module: `isa_ide_bridge`

## Requirements
- R1: Only addresses whose bits above [3:0] equal those of the BASE_ADDR parameter are claimed. A request outside the window produces no acknowledge, no ATA strobe and no change of the host read data.
- R2: A read at offset 0 runs one 16-bit ATA read with chip select 0 asserted and register address 0. It returns bits [7:0] of the drive word to the host and stores bits [15:8] in the holding register.
- R3: A write at offset 0 runs one 16-bit ATA write with chip select 0 and register address 0. The word on the bus is {holding register, host byte}.
- R4: A read or write at offset 8 reads or loads the holding register and runs no ATA cycle.
- R5: Offsets 1 to 7 run 8-bit ATA cycles with chip select 0 asserted and register address equal to the offset. On a write, bits [15:8] of the outgoing word are zero, and on a read only bits [7:0] of the drive word reach the host.
- R6: Offset 0xE runs an ATA cycle with chip select 1 asserted and register address 6. A write carries device-control data, and a read returns the alternate-status byte.
- R7: A read at an unused offset (9 to 0xD, 0xF) returns 0xFF. A write there changes nothing. Neither runs an ATA cycle, and both are acknowledged one cycle after the request.
- R8: Reset clears the holding register to 0x00, deasserts both chip selects and both strobes active-high (idle level 1), and holds the acknowledge low.
- R9: Each ATA strobe stays low for exactly STROBE_CYCLES clocks, and the read and write strobes are never low together. The acknowledge is high for one clock: the first clock after the strobe returns high, STROBE_CYCLES+1 clocks after the request.
- R10: A request that arrives while an access is still in progress is ignored. It starts no cycle and produces no acknowledge of its own.
- R11: The host read data holds its value from one acknowledged read until the next claimed access loads it, even if the drive's data changes in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Host I/O address |
| hostWrData | input | 8 | Host write byte |
| hostIor | input | 1 | One-cycle host read request (takes priority over a write request) |
| hostIow | input | 1 | One-cycle host write request |
| hostRdData | output | 8 | Host read byte, held until the next claimed access |
| hostAck | output | 1 | One-cycle access-complete pulse |
| ideCs0N | output | 1 | ATA command-block chip select, active low |
| ideCs1N | output | 1 | ATA control-block chip select, active low |
| ideAddr | output | 3 | ATA register address |
| ideDataOut | output | 16 | ATA write data word |
| ideDataOe | output | 1 | High while the bridge drives the ATA data bus |
| ideDataIn | input | 16 | ATA read data word |
| ideDiorN | output | 1 | ATA read strobe, active low |
| ideDiowN | output | 1 | ATA write strobe, active low |

## Verification
The bench builds the bridge with BASE_ADDR at the alternate window 0x360 and STROBE_CYCLES set to 3. A window that is not at the default base shows that the decode follows the parameter and does not rely on a fixed address. A probe at 0x300 also checks that the default window is not claimed. The short strobe keeps each access a few clocks long, so several hundred random accesses fit in the run. A request placed in the middle of a strobe, with the exact acknowledge latency as the expected value, checks the busy-ignore rule and the capture timing.

// File: rtl/isa_ide_pkg.sv
package isa_ide_pkg;

  // Kind of access selected by the window offset.
  typedef enum logic [2:0] {
    ACC_DATA  = 3'd0,
    ACC_TASK  = 3'd1,
    ACC_LATCH = 3'd2,
    ACC_CTRL  = 3'd3,
    ACC_VOID  = 3'd4
  } acc_kind_e;

  // Strobes that the control sends to the datapath.
  typedef struct packed {
    logic      start;       // request accepted this cycle
    logic      startWrite;  // accepted request is a write
    acc_kind_e startKind;   // kind of accepted request
    logic      capture;     // last strobe cycle of an ATA read
    acc_kind_e heldKind;    // kind of access in progress
  } bridge_ctl_t;

  function automatic logic kindUsesBus(acc_kind_e k);
    return (k == ACC_DATA) || (k == ACC_TASK) || (k == ACC_CTRL);
  endfunction

endpackage

// File: rtl/isa_ide_decode.sv
module isa_ide_decode
  import isa_ide_pkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h300
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output acc_kind_e         kind,
  output logic [2:0]        regAddr
);
  localparam int OFF_W = 4;
  localparam logic [2:0] CTRL_REG = 3'd6;

  logic [OFF_W-1:0] offset;

  assign offset = addr[OFF_W-1:0];
  assign hit    = (addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);

  always_comb begin
    case (offset)
      4'd0:                                  kind = ACC_DATA;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: kind = ACC_TASK;
      4'd8:                                  kind = ACC_LATCH;
      4'hE:                                  kind = ACC_CTRL;
      default:                               kind = ACC_VOID;
    endcase
  end

  assign regAddr = (kind == ACC_CTRL) ? CTRL_REG : offset[2:0];

endmodule

// File: rtl/isa_ide_ctrl.sv
module isa_ide_ctrl
  import isa_ide_pkg::*;
#(
  parameter int STROBE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostIor,
  input  logic        hostIow,
  input  logic        hit,
  input  acc_kind_e   kind,
  input  logic [2:0]  regAddr,
  output bridge_ctl_t ctl,
  output logic        hostAck,
  output logic        ideCs0N,
  output logic        ideCs1N,
  output logic [2:0]  ideAddr,
  output logic        ideDataOe,
  output logic        ideDiorN,
  output logic        ideDiowN
);
  localparam int CNT_W = $clog2(STROBE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_ACK} state_e;

  state_e      state;
  logic [CNT_W-1:0] cnt;
  acc_kind_e   heldKind;
  logic [2:0]  heldAddr;
  logic        heldWrite;
  logic        start;
  logic        active;

  assign start  = (state == ST_IDLE) && hit && (hostIor || hostIow);
  assign active = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      heldKind  <= ACC_VOID;
      heldAddr  <= '0;
      heldWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            heldKind  <= kind;
            heldAddr  <= regAddr;
            heldWrite <= !hostIor;   // read wins if both pulse
            cnt       <= '0;
            state     <= kindUsesBus(kind) ? ST_STROBE : ST_ACK;
          end
        end
        ST_STROBE: begin
          if (cnt == LAST) state <= ST_ACK;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.start      = start;
    ctl.startWrite = !hostIor;
    ctl.startKind  = kind;
    ctl.capture    = (state == ST_STROBE) && (cnt == LAST) && !heldWrite;
    ctl.heldKind   = heldKind;
  end

  assign hostAck   = (state == ST_ACK);
  assign ideCs0N   = !(active && (heldKind == ACC_DATA || heldKind == ACC_TASK));
  assign ideCs1N   = !(active && (heldKind == ACC_CTRL));
  assign ideAddr   = heldAddr;
  assign ideDataOe = active && heldWrite && kindUsesBus(heldKind);
  assign ideDiorN  = !((state == ST_STROBE) && !heldWrite);
  assign ideDiowN  = !((state == ST_STROBE) && heldWrite);

  // Strobe length measured independently of the state counter.
  logic [CNT_W:0] chkLen;
  always_ff @(posedge clk) begin
    if (!rstN)                      chkLen <= '0;
    else if (!ideDiorN || !ideDiowN) chkLen <= chkLen + 1'b1;
    else                            chkLen <= '0;
  end

  // R9
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ideDiorN && ideDiowN && chkLen != 0) |-> (chkLen == (CNT_W+1)'(STROBE_CYCLES)));

  // R9
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ideDiorN) || $rose(ideDiowN)) |-> hostAck);

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);

  // R6
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!ideCs0N && !ideCs1N));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE) |=> ($stable(heldAddr) && $stable(heldWrite)));

endmodule

// File: rtl/isa_ide_dpath.sv
module isa_ide_dpath
  import isa_ide_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  bridge_ctl_t ctl,
  input  logic [7:0]  hostWrData,
  input  logic [15:0] ideDataIn,
  output logic [7:0]  hostRdData,
  output logic [15:0] ideDataOut
);
  localparam logic [7:0] VOID_BYTE = 8'hFF;

  logic [7:0]  hiLatch;
  logic [15:0] wordOut;
  logic [7:0]  rdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiLatch <= '0;
    end else if (ctl.start && ctl.startWrite && ctl.startKind == ACC_LATCH) begin
      hiLatch <= hostWrData;
    end else if (ctl.capture && ctl.heldKind == ACC_DATA) begin
      hiLatch <= ideDataIn[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordOut <= '0;
    end else if (ctl.start && ctl.startWrite && kindUsesBus(ctl.startKind)) begin
      wordOut <= (ctl.startKind == ACC_DATA) ? {hiLatch, hostWrData}
                                             : {8'h00, hostWrData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdReg <= '0;
    end else if (ctl.start && !ctl.startWrite && ctl.startKind == ACC_LATCH) begin
      rdReg <= hiLatch;
    end else if (ctl.start && !ctl.startWrite && ctl.startKind == ACC_VOID) begin
      rdReg <= VOID_BYTE;
    end else if (ctl.capture) begin
      rdReg <= ideDataIn[7:0];
    end
  end

  assign hostRdData = rdReg;
  assign ideDataOut = wordOut;

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.start && !ctl.capture) |=> $stable(hostRdData));

  // R7
  void_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && !ctl.startWrite && ctl.startKind == ACC_VOID) |=> (hostRdData == 8'hFF));

  // R2
  latch_from_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.heldKind == ACC_DATA) |=> (hiLatch == $past(ideDataIn[15:8])));

endmodule

// File: rtl/isa_ide_bridge.sv
module isa_ide_bridge
  import isa_ide_pkg::*;
#(
  parameter int                ADDR_W        = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR     = 'h300,
  parameter int                STROBE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  input  logic              hostIor,
  input  logic              hostIow,
  output logic [7:0]        hostRdData,
  output logic              hostAck,
  output logic              ideCs0N,
  output logic              ideCs1N,
  output logic [2:0]        ideAddr,
  output logic [15:0]       ideDataOut,
  output logic              ideDataOe,
  input  logic [15:0]       ideDataIn,
  output logic              ideDiorN,
  output logic              ideDiowN
);
  logic        hit;
  acc_kind_e   kind;
  logic [2:0]  regAddr;
  bridge_ctl_t ctl;

  isa_ide_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) decode_i (
    .addr(hostAddr), .hit(hit), .kind(kind), .regAddr(regAddr)
  );

  isa_ide_ctrl #(.STROBE_CYCLES(STROBE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostIor(hostIor), .hostIow(hostIow),
    .hit(hit), .kind(kind), .regAddr(regAddr), .ctl(ctl),
    .hostAck(hostAck), .ideCs0N(ideCs0N), .ideCs1N(ideCs1N),
    .ideAddr(ideAddr), .ideDataOe(ideDataOe),
    .ideDiorN(ideDiorN), .ideDiowN(ideDiowN)
  );

  isa_ide_dpath dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostWrData(hostWrData),
    .ideDataIn(ideDataIn), .hostRdData(hostRdData), .ideDataOut(ideDataOut)
  );

endmodule

// File: tb/isa_ide_bridge_tb_top.sv
module isa_ide_bridge_tb_top;
  localparam int              ADDR_W = 10;
  localparam logic [9:0]      BASE   = 10'h360;
  localparam int              NSTB   = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN;
  logic [ADDR_W-1:0] hostAddr;
  logic [7:0]        hostWrData;
  logic              hostIor, hostIow;
  logic [7:0]        hostRdData;
  logic              hostAck;
  logic              ideCs0N, ideCs1N, ideDataOe, ideDiorN, ideDiowN;
  logic [2:0]        ideAddr;
  logic [15:0]       ideDataOut, ideDataIn;

  isa_ide_bridge #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .STROBE_CYCLES(NSTB)) dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostIor(hostIor), .hostIow(hostIow), .hostRdData(hostRdData), .hostAck(hostAck),
    .ideCs0N(ideCs0N), .ideCs1N(ideCs1N), .ideAddr(ideAddr), .ideDataOut(ideDataOut),
    .ideDataOe(ideDataOe), .ideDataIn(ideDataIn), .ideDiorN(ideDiorN), .ideDiowN(ideDiowN)
  );

  // Drive model (owned by the main process)
  logic [15:0] drvData;
  logic [7:0]  drvTask [8];
  logic [7:0]  drvDevCtl;
  logic [7:0]  drvAltStat;

  always_comb begin
    if (!ideCs0N)      ideDataIn = (ideAddr == 3'd0) ? drvData : {8'hC3, drvTask[ideAddr]};
    else if (!ideCs1N) ideDataIn = (ideAddr == 3'd6) ? {8'h5A, drvAltStat} : 16'h0000;
    else               ideDataIn = 16'hFFFF;
  end

  // Bus monitor (own counters)
  int monChecks = 0, monFails = 0;
  int iorPulses = 0, iowPulses = 0;
  int rdLen = 0, wrLen = 0;
  logic [15:0] lastWrWord = '0;
  logic        lastWrCs0 = 1'b0, lastWrCs1 = 1'b0;
  logic [2:0]  lastWrAddr = '0, lastRdAddr = '0;
  logic        lastRdCs0 = 1'b0, lastRdCs1 = 1'b0;

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      monChecks++;
      if (!ideDiorN && !ideDiowN) begin
        monFails++;
        $display("FAIL R9 both strobes low: actual dior=%b diow=%b expected not both 0", ideDiorN, ideDiowN);
      end
      if (!ideDiorN) begin
        rdLen++;
        lastRdCs0 = !ideCs0N; lastRdCs1 = !ideCs1N; lastRdAddr = ideAddr;
      end else if (rdLen > 0) begin
        iorPulses++; monChecks++;
        if (rdLen != NSTB) begin
          monFails++;
          $display("FAIL R9 read strobe width: actual %0d expected %0d", rdLen, NSTB);
        end
        rdLen = 0;
      end
      if (!ideDiowN) begin
        wrLen++;
        lastWrWord = ideDataOut; lastWrCs0 = !ideCs0N; lastWrCs1 = !ideCs1N; lastWrAddr = ideAddr;
        monChecks++;
        if (!ideDataOe) begin
          monFails++;
          $display("FAIL R3 data bus not driven during write: actual oe=%b expected 1", ideDataOe);
        end
      end else if (wrLen > 0) begin
        iowPulses++; monChecks++;
        if (wrLen != NSTB) begin
          monFails++;
          $display("FAIL R9 write strobe width: actual %0d expected %0d", wrLen, NSTB);
        end
        wrLen = 0;
      end
    end
  end

  int  checks = 0, failures = 0;
  bit  done = 1'b0;
  logic [7:0] latchModel;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int kindOf(input logic [3:0] off);
    if (off == 4'd0) return 0;
    if (off <= 4'd7) return 1;
    if (off == 4'd8) return 2;
    if (off == 4'hE) return 3;
    return 4;
  endfunction

  function automatic string reqOf(input logic [3:0] off, input bit wr);
    case (kindOf(off))
      0: return wr ? "R3" : "R2";
      1: return "R5";
      2: return "R4";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  // One acknowledged access in the window, fully checked.
  task automatic hostOp(input logic [3:0] off, input bit wr, input logic [7:0] b);
    int k, lat, ior0, iow0, expLat;
    logic [7:0] expRd;
    string req;
    bit ide;
    k = kindOf(off); req = reqOf(off, wr);
    ide = (k == 0) || (k == 1) || (k == 3);
    expLat = ide ? NSTB + 1 : 1;
    ior0 = iorPulses; iow0 = iowPulses;
    case (k)
      0: expRd = drvData[7:0];
      1: expRd = drvTask[off[2:0]];
      2: expRd = latchModel;
      3: expRd = drvAltStat;
      default: expRd = 8'hFF;
    endcase
    hostAddr = BASE | {6'd0, off}; hostWrData = b;
    hostIor = !wr; hostIow = wr;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin hostIor = 1'b0; hostIow = 1'b0; end
      if (hostAck || lat > 40) break;
    end
    #1;
    chk({req, "/R9 ack latency"}, lat, expLat);
    chk({req, " read strobes"}, iorPulses - ior0, (ide && !wr) ? 1 : 0);
    chk({req, " write strobes"}, iowPulses - iow0, (ide && wr) ? 1 : 0);
    if (!wr) begin
      chk({req, " read data"}, hostRdData, expRd);
      if (ide) chk({req, " read select"}, {lastRdCs0, lastRdCs1, lastRdAddr},
                   (k == 3) ? {2'b01, 3'd6} : {2'b10, off[2:0]});
      if (k == 0) latchModel = drvData[15:8];
    end else begin
      case (k)
        0: begin
          chk("R3 write word", {lastWrCs0, lastWrCs1, lastWrAddr, lastWrWord},
              {2'b10, 3'd0, latchModel, b});
          drvData = lastWrWord;
        end
        1: begin
          chk("R5 write word", {lastWrCs0, lastWrCs1, lastWrAddr, lastWrWord},
              {2'b10, off[2:0], 8'h00, b});
          drvTask[off[2:0]] = lastWrWord[7:0];
        end
        2: latchModel = b;
        3: begin
          chk("R6 write word", {lastWrCs0, lastWrCs1, lastWrAddr, lastWrWord[7:0]},
              {2'b01, 3'd6, b});
          drvDevCtl = lastWrWord[7:0];
        end
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  // Request outside the window: nothing must happen.
  task automatic missOp(input logic [ADDR_W-1:0] a, input bit wr);
    int ior0, iow0, acks;
    logic [7:0] rd0;
    ior0 = iorPulses; iow0 = iowPulses; rd0 = hostRdData; acks = 0;
    hostAddr = a; hostWrData = 8'h5C; hostIor = !wr; hostIow = wr;
    for (int i = 0; i < NSTB + 4; i++) begin
      @(negedge clk);
      hostIor = 1'b0; hostIow = 1'b0;
      if (hostAck) acks++;
    end
    #1;
    chk("R1 no ack outside window", acks, 0);
    chk("R1 no strobe outside window", (iorPulses - ior0) + (iowPulses - iow0), 0);
    chk("R1 read data unchanged", hostRdData, rd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks + monChecks + 1, failures + monFails + 1);
      $finish;
    end
  end

  initial begin
    int acks, ior0, iow0;
    logic [7:0] held;
    void'($urandom(32'd1357));
    rstN = 1'b0; hostAddr = '0; hostWrData = '0; hostIor = 1'b0; hostIow = 1'b0;
    drvData = 16'h0000; drvDevCtl = 8'h00; drvAltStat = 8'h50;
    for (int i = 0; i < 8; i++) drvTask[i] = 8'(i * 17);
    latchModel = 8'h00;
    repeat (5) @(negedge clk);
    chk("R8 idle outputs in reset", {ideCs0N, ideCs1N, ideDiorN, ideDiowN, hostAck}, 5'b11110);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 idle outputs after reset", {ideCs0N, ideCs1N, ideDiorN, ideDiowN, hostAck}, 5'b11110);
    hostOp(4'd8, 1'b0, 8'h00);                 // R8 latch reads zero
    chk("R8 latch cleared", hostRdData, 8'h00);

    // R2 / R4 / R3
    drvData = 16'hBEEF;
    hostOp(4'd0, 1'b0, 8'h00);
    hostOp(4'd8, 1'b0, 8'h00);
    chk("R2 high byte parked", hostRdData, 8'hBE);
    hostOp(4'd8, 1'b1, 8'h12);
    hostOp(4'd0, 1'b1, 8'h34);
    chk("R3 drive word", drvData, 16'h1234);
    hostOp(4'd8, 1'b0, 8'h00);
    chk("R4 latch kept across data write", hostRdData, 8'h12);

    // R5 / R6
    hostOp(4'd3, 1'b1, 8'h77);
    drvTask[5] = 8'h9C;
    hostOp(4'd5, 1'b0, 8'h00);
    hostOp(4'hE, 1'b1, 8'h02);
    chk("R6 device control stored", drvDevCtl, 8'h02);
    hostOp(4'hE, 1'b0, 8'h00);

    // R7 unused offsets
    hostOp(4'd9, 1'b0, 8'h00);
    hostOp(4'hB, 1'b1, 8'hAA);
    hostOp(4'hF, 1'b1, 8'h55);
    hostOp(4'd8, 1'b0, 8'h00);
    chk("R7 unused write left latch", hostRdData, 8'h12);

    // R1 outside the window
    missOp(10'h300, 1'b0);
    missOp(10'h370, 1'b1);
    missOp(10'h35F, 1'b0);

    // R10 request during a strobe
    ior0 = iorPulses; iow0 = iowPulses; acks = 0;
    hostAddr = BASE | 10'd3; hostWrData = 8'h66; hostIow = 1'b1;
    @(negedge clk);
    hostIow = 1'b0; hostIor = 1'b1; hostAddr = BASE | 10'd5;
    @(negedge clk);
    hostIor = 1'b0;
    for (int i = 0; i < NSTB + 6; i++) begin
      @(negedge clk);
      if (hostAck) acks++;
    end
    #1;
    chk("R10 single ack", acks, 1);
    chk("R10 no extra read", iorPulses - ior0, 0);
    chk("R10 one write", iowPulses - iow0, 1);
    chk("R10 first request word", {lastWrAddr, lastWrWord}, {3'd3, 16'h0066});
    drvTask[3] = 8'h66;

    // R11 read data held
    drvTask[2] = 8'h3E;
    hostOp(4'd2, 1'b0, 8'h00);
    held = hostRdData;
    drvTask[2] = 8'hE3;
    repeat (6) @(negedge clk);
    chk("R11 read data held", hostRdData, held);
    chk("R11 held value", held, 8'h3E);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [3:0] off;
      bit wr;
      off = 4'($urandom % 16);
      wr  = 1'($urandom % 2);
      if (off == 4'd0 && !wr) drvData = 16'($urandom);
      if ($urandom % 8 == 0) drvAltStat = 8'($urandom);
      hostOp(off, wr, 8'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks + monChecks, failures + monFails);
    $finish;
  end

endmodule